// File: doc/BRIEF.md
# Indexed RGB Colour Lookup Table

This block is a colour lookup table for a display pipeline. It holds 256 entries, and each entry stores red, green and blue at 6 bits per component. A processor reaches it through four byte-wide registers: a load pointer, a fetch pointer, a shared data register and a pixel mask. Each access to the data register moves exactly one colour component. A per-pointer component counter steps through red, green and blue. After blue, the pointer moves to the next entry.

On the display side, the top bits of the incoming pixel word form the table index. The index is ANDed with the mask, and the selected colour triple appears on registered outputs one clock later. The processor can reload the whole table by writing the load pointer once and then streaming 768 data bytes. It can check the table by doing the same with the fetch pointer.

Register select codes on `bus_sel`: 0 is the load pointer, 1 is the data register, 2 is the fetch pointer and 3 is the pixel mask.

Top module: `clut_rgb_port`

## Requirements
- R1: A write with `bus_sel`=0 sets the load pointer to `bus_wdata` and sets its component counter to red. A read with `bus_sel`=0 returns the load pointer.
- R2: A write with `bus_sel`=2 sets the fetch pointer to `bus_wdata` and sets its component counter to red. A read with `bus_sel`=2 returns the fetch pointer.
- R3: Successive data writes (`bus_sel`=1) store red, then green, then blue of the entry at the load pointer. After blue, the load pointer increments, and it wraps from 255 to 0.
- R4: Successive data reads (`bus_sel`=1) return red, then green, then blue of the entry at the fetch pointer. A read advances the counter at the clock edge that ends it. After blue, the fetch pointer increments, and it wraps from 255 to 0.
- R5: Only `bus_wdata[5:0]` is stored. A data read returns the stored component on bits 5:0, with bits 7:6 equal to 0.
- R6: The lookup index is `pix_in[PIX_W-1:PIX_W-8]` AND the mask. A mask of 0xFF leaves the index unchanged. A read with `bus_sel`=3 returns the last mask written.
- R7: `pix_red`, `pix_green` and `pix_blue` show the entry selected by `pix_in` as it stood at the previous rising clock edge.
- R8: If a data write and a lookup hit the same entry at the same edge, that lookup returns the old component. Lookups from the next edge onward return the new one.
- R9: After reset, both pointers are 0, both counters are at red, the mask is 0xFF and the pixel outputs are 0.
- R10: If `bus_wr` and `bus_rd` are both high on the data register, the write is done and the read has no effect on the fetch pointer or its counter.
- R11: Writing a pointer register in the middle of a triple restarts its counter at red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select (0 load ptr, 1 data, 2 fetch ptr, 3 mask) |
| bus_wr | input | 1 | Register write strobe, one access per cycle high |
| bus_rd | input | 1 | Register read strobe, one access per cycle high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pix_in | input | PIX_W | Pixel word; the top 8 bits give the index |
| pix_red | output | 6 | Red of the looked-up entry |
| pix_green | output | 6 | Green of the looked-up entry |
| pix_blue | output | 6 | Blue of the looked-up entry |

## Verification
The bench loads all 256 entries through a single pointer write and then confirms that the load pointer has wrapped back to 0. A design that mis-wraps or advances on the wrong component would leave a nonzero pointer and shuffled colours. It reads the whole table back and sweeps every pixel word, with the mask open and then narrowed. A lookup that used the low pixel bits, or ignored the mask, would return the wrong triple. Targeted tests cover the rest:
- a same-edge write and lookup, which catches a bypass that shows the new value one cycle early;
- simultaneous read and write strobes, which catch a stray advance of the fetch pointer;
- a pointer rewritten mid-triple, which catches a counter that is not restarted;
- data bytes with the top bits set, which catch storage or readback of bits 7:6.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    SEL_LOAD_PTR  = 2'd0,
    SEL_DATA      = 2'd1,
    SEL_FETCH_PTR = 2'd2,
    SEL_MASK      = 2'd3
  } clut_sel_e;

  typedef enum logic [1:0] {
    CMP_RED   = 2'd0,
    CMP_GREEN = 2'd1,
    CMP_BLUE  = 2'd2
  } clut_cmp_e;

  localparam int unsigned NUM_CMP = 3;

endpackage

// File: rtl/clut_ptr_seq.sv
module clut_ptr_seq
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  output logic [ADDR_W-1:0] ptr_q,
  output clut_cmp_e         cmp_q
);

  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] ptr_d;
  clut_cmp_e         cmp_d;
  logic              upd_en;

  assign upd_en = load_en | step_en;

  always_comb begin
    ptr_d = ptr_q;
    cmp_d = cmp_q;
    if (load_en) begin
      ptr_d = load_val;
      cmp_d = CMP_RED;
    end else if (step_en) begin
      unique case (cmp_q)
        CMP_RED:   cmp_d = CMP_GREEN;
        CMP_GREEN: cmp_d = CMP_BLUE;
        default: begin
          cmp_d = CMP_RED;
          ptr_d = ptr_q + PTR_ONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cmp_q <= CMP_RED;
    end else if (upd_en) begin
      ptr_q <= ptr_d;
      cmp_q <= cmp_d;
    end
  end

  assert_cmp_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q != 2'd3);

  assert_load_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cmp_q == CMP_RED) && (ptr_q == $past(load_val)));

  assert_advance_after_blue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && cmp_q == CMP_BLUE) |=>
      (cmp_q == CMP_RED) && (ptr_q == $past(ptr_q) + PTR_ONE));

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && cmp_q == CMP_BLUE && ptr_q == PTR_MAX) |=>
      (ptr_q == '0));

  assert_hold_mid_triple_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && cmp_q != CMP_BLUE) |=> $stable(ptr_q));

endmodule

// File: rtl/clut_pix_index.sv
module clut_pix_index #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [PIX_W-1:0]  pix_in,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] lut_addr
);

  logic [ADDR_W-1:0] top_bits;

  generate
    if (PIX_W == ADDR_W) begin : g_exact
      assign top_bits = pix_in;
    end else begin : g_wide
      logic [PIX_W-ADDR_W-1:0] low_bits_unused;
      assign top_bits        = pix_in[PIX_W-1 -: ADDR_W];
      assign low_bits_unused = pix_in[PIX_W-ADDR_W-1:0];
    end
  endgenerate

  assign lut_addr = top_bits & mask;

endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CMP_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  clut_cmp_e         wr_cmp,
  input  logic [CMP_W-1:0]  wr_val,
  input  logic [ADDR_W-1:0] rd_addr,
  input  clut_cmp_e         rd_cmp,
  output logic [CMP_W-1:0]  rd_val,
  input  logic [ADDR_W-1:0] pix_addr,
  output logic [CMP_W-1:0]  pix_val [NUM_CMP]
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [CMP_W-1:0] cells [NUM_CMP][DEPTH];
  logic [CMP_W-1:0] pix_d [NUM_CMP];

  generate
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_plane
      logic plane_we;
      assign plane_we = wr_en && (wr_cmp == clut_cmp_e'(c));

      always_ff @(posedge clk) begin
        if (plane_we) begin
          cells[c][wr_addr] <= wr_val;
        end
      end

      assign pix_d[c] = cells[c][pix_addr];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pix_val[c] <= '0;
        end else begin
          pix_val[c] <= pix_d[c];
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (rd_cmp)
      CMP_RED:   rd_val = cells[0][rd_addr];
      CMP_GREEN: rd_val = cells[1][rd_addr];
      default:   rd_val = cells[2][rd_addr];
    endcase
  end

  assert_write_not_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cmp == CMP_RED && wr_addr == pix_addr) |=>
      (pix_val[0] == $past(cells[0][pix_addr])));

endmodule

// File: rtl/clut_rgb_port.sv
module clut_rgb_port
  import clut_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CMP_W  = 6,
  parameter int unsigned BUS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [PIX_W-1:0] pix_in,
  output logic [CMP_W-1:0] pix_red,
  output logic [CMP_W-1:0] pix_green,
  output logic [CMP_W-1:0] pix_blue
);

  clut_sel_e sel;
  assign sel = clut_sel_e'(bus_sel);

  logic load_ptr_we, fetch_ptr_we, mask_we, data_we, data_re;

  assign load_ptr_we  = bus_wr && (sel == SEL_LOAD_PTR);
  assign fetch_ptr_we = bus_wr && (sel == SEL_FETCH_PTR);
  assign mask_we      = bus_wr && (sel == SEL_MASK);
  assign data_we      = bus_wr && (sel == SEL_DATA);
  assign data_re      = bus_rd && !bus_wr && (sel == SEL_DATA);

  logic [ADDR_W-1:0] load_ptr, fetch_ptr, mask_q, mask_d, lut_addr;
  clut_cmp_e         load_cmp, fetch_cmp;
  logic [CMP_W-1:0]  fetch_val;
  logic [CMP_W-1:0]  pix_val [NUM_CMP];

  clut_ptr_seq #(.ADDR_W(ADDR_W)) i_load_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_ptr_we),
    .load_val (bus_wdata[ADDR_W-1:0]),
    .step_en  (data_we),
    .ptr_q    (load_ptr),
    .cmp_q    (load_cmp)
  );

  clut_ptr_seq #(.ADDR_W(ADDR_W)) i_fetch_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (fetch_ptr_we),
    .load_val (bus_wdata[ADDR_W-1:0]),
    .step_en  (data_re),
    .ptr_q    (fetch_ptr),
    .cmp_q    (fetch_cmp)
  );

  assign mask_d = mask_we ? bus_wdata[ADDR_W-1:0] : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  clut_pix_index #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) i_pix_index (
    .pix_in   (pix_in),
    .mask     (mask_q),
    .lut_addr (lut_addr)
  );

  clut_store #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (data_we),
    .wr_addr  (load_ptr),
    .wr_cmp   (load_cmp),
    .wr_val   (bus_wdata[CMP_W-1:0]),
    .rd_addr  (fetch_ptr),
    .rd_cmp   (fetch_cmp),
    .rd_val   (fetch_val),
    .pix_addr (lut_addr),
    .pix_val  (pix_val)
  );

  assign pix_red   = pix_val[0];
  assign pix_green = pix_val[1];
  assign pix_blue  = pix_val[2];

  always_comb begin
    unique case (sel)
      SEL_LOAD_PTR:  bus_rdata = BUS_W'(load_ptr);
      SEL_DATA:      bus_rdata = BUS_W'(fetch_val);
      SEL_FETCH_PTR: bus_rdata = BUS_W'(fetch_ptr);
      default:       bus_rdata = BUS_W'(mask_q);
    endcase
  end

  assert_mask_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(bus_wdata[ADDR_W-1:0])));

  assert_collision_read_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd && sel == SEL_DATA) |=> ($stable(fetch_ptr) && $stable(fetch_cmp)));

  assert_upper_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DATA) |-> (bus_rdata[BUS_W-1:CMP_W] == '0));

endmodule

// File: tb/test_clut_rgb_port.sv
`timescale 1ns/1ps
module test_clut_rgb_port;

  localparam int PIX_W = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [PIX_W-1:0] pix_in = '0;
  logic [5:0] pix_red, pix_green, pix_blue;

  int total = 0;
  int bad = 0;

  logic [5:0] exp_r [256];
  logic [5:0] exp_g [256];
  logic [5:0] exp_b [256];

  always #4 clk = ~clk;

  clut_rgb_port #(.PIX_W(PIX_W)) i_clut_rgb_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_in(pix_in),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
  );

  function automatic logic [5:0] fr(int i); return 6'(i); endfunction
  function automatic logic [5:0] fg(int i); return 6'(i * 5 + 3); endfunction
  function automatic logic [5:0] fb(int i); return 6'(i ^ 8'hA5); endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic int pix_exp(int idx);
    return {exp_r[idx], exp_g[idx], exp_b[idx]};
  endfunction

  task automatic pixel_sweep(string req, logic [7:0] mask);
    int prev_idx = 0;
    int errs = 0;
    for (int p = 0; p <= (1 << PIX_W); p++) begin
      @(negedge clk);
      if (p > 0) begin
        if ({pix_red, pix_green, pix_blue} != 18'(pix_exp(prev_idx))) begin
          errs++;
          if (errs < 4)
            check(req, {pix_red, pix_green, pix_blue}, pix_exp(prev_idx));
        end
      end
      if (p < (1 << PIX_W)) begin
        pix_in = PIX_W'(p);
        prev_idx = (p >> (PIX_W - 8)) & mask;
      end
    end
    check({req, " sweep errors"}, errs, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    bus_read(2'd0, d); check("R9 load ptr", d, 0);
    bus_read(2'd2, d); check("R9 fetch ptr", d, 0);
    bus_read(2'd3, d); check("R9 mask", d, 8'hFF);
    check("R9 pixel out", {pix_red, pix_green, pix_blue}, 0);

    // R1/R3/R5: fill the table through one pointer write, top bits set
    bus_write(2'd0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      exp_r[i] = fr(i); exp_g[i] = fg(i); exp_b[i] = fb(i);
      bus_write(2'd1, {2'b11, fr(i)});
      bus_write(2'd1, {2'b10, fg(i)});
      bus_write(2'd1, {2'b01, fb(i)});
    end
    bus_read(2'd0, d); check("R3 load ptr wrapped", d, 0);

    // R2/R4/R5: read back the full table
    bus_write(2'd2, 8'd0);
    begin
      int errs = 0;
      for (int i = 0; i < 256; i++) begin
        logic [7:0] a, b, c;
        bus_read(2'd1, a); bus_read(2'd1, b); bus_read(2'd1, c);
        if (a != {2'b00, exp_r[i]} || b != {2'b00, exp_g[i]} || c != {2'b00, exp_b[i]}) begin
          errs++;
          if (errs < 4) check("R4 R5 readback", {a, b, c}, {2'b00, exp_r[i], 2'b00, exp_g[i], 2'b00, exp_b[i]});
        end
      end
      check("R4 R5 readback errors", errs, 0);
    end
    bus_read(2'd2, d); check("R4 fetch ptr wrapped", d, 0);

    // R1/R2: pointer load and readback
    bus_write(2'd0, 8'd77); bus_read(2'd0, d); check("R1 load ptr readback", d, 77);
    bus_write(2'd2, 8'd201); bus_read(2'd2, d); check("R2 fetch ptr readback", d, 201);
    bus_read(2'd1, d); check("R2 fetch at new ptr", d, exp_r[201]);

    // R6/R7: sweep all pixel words, mask open, then narrowed
    pixel_sweep("R7 R6 open mask", 8'hFF);
    bus_write(2'd3, 8'h5A); bus_read(2'd3, d); check("R6 mask readback", d, 8'h5A);
    pixel_sweep("R6 mask 0x5A", 8'h5A);
    bus_write(2'd3, 8'hFF);

    // R8: same-edge write and lookup of entry 5
    bus_write(2'd0, 8'd5);
    @(negedge clk);
    pix_in = PIX_W'(5 << (PIX_W - 8));
    bus_sel = 2'd1; bus_wdata = 8'd60; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R8 old value on same edge", pix_red, exp_r[5]);
    exp_r[5] = 6'd60;
    @(negedge clk);
    check("R8 new value next edge", pix_red, 60);

    // R10: simultaneous read and write strobes on data
    bus_write(2'd2, 8'd10);
    bus_write(2'd0, 8'd11);
    @(negedge clk);
    bus_sel = 2'd1; bus_wdata = 8'd33; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    exp_r[11] = 6'd33;
    bus_read(2'd1, d); check("R10 fetch not advanced", d, exp_r[10]);
    bus_write(2'd2, 8'd11); bus_read(2'd1, d); check("R10 write done", d, 33);

    // R11: pointer rewrite mid-triple restarts at red
    bus_write(2'd0, 8'd20);
    bus_write(2'd1, 8'd1);
    bus_write(2'd0, 8'd20);
    bus_write(2'd1, 8'd2);
    exp_r[20] = 6'd2;
    bus_write(2'd2, 8'd20);
    bus_read(2'd1, d); check("R11 load restart red", d, 2);
    bus_read(2'd1, d); check("R11 green untouched", d, exp_g[20]);
    bus_write(2'd2, 8'd20);
    bus_read(2'd1, d); check("R11 fetch restart red", d, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule